// File: doc/BRIEF.md
# SONET/SDH Serial Byte Aligner and Frame Detector

This block takes a serial SONET/SDH line stream, one bit per cycle of its bit clock, and turns it into bytes. A byte strobe pulses once for every completed byte, so the strobe runs at one eighth of the bit rate. The block also watches every bit position of the stream for the framing pattern: a run of A1 bytes (8'hF6) followed by three A2 bytes (8'h28). It compares the bits most significant first, in the order they arrive. How many A1 bytes are needed depends on the rate mode.

An out-of-frame level input lets the framing pattern move the byte boundary. While that input is high, a pattern found at any bit offset re-aligns the byte boundary so that the third A2 becomes a whole output byte. A sync pulse is raised on that byte. While the input is low, the boundary is never moved, and a match found at the bit level is only reported by a sync pulse. A framer-enable input suppresses all sync pulses but keeps the current alignment. An active-low signal-loss input forces the incoming bits to zero, so the bytes read out are zero and no pattern can match.

Top module: `sonet_byte_framer`

## Requirements
- R1: Each completed byte is presented on `byte_out` with a one-cycle `byte_stb` pulse. When no re-alignment occurs, strobes come every 8 bit clocks. Bit 7 (MSB) of `byte_out` holds the earliest-received bit of the byte.
- R2: The synchronous active-low reset `rst_n` clears `byte_out`, `byte_stb` and `sync_out` to zero. It also puts the byte boundary at offset 0: the first 8 bits sampled after release form the first byte.
- R3: With `rate_sts3` = 0 the pattern is twelve 8'hF6 bytes followed by three 8'h28 bytes. With `rate_sts3` = 1 the pattern is three 8'hF6 bytes followed by three 8'h28 bytes. In STS-12 mode the shorter pattern alone does not match.
- R4: While `oof` is high, a match ending at any bit offset closes a byte on the edge that samples the pattern's last bit. At that strobe `byte_out` = 8'h28 and `sync_out` = 1, and later bytes follow the new boundary.
- R5: While `oof` is low, the byte boundary is unchanged. A match raises `sync_out` on the strobe of the byte that contains the pattern's last bit. When the stream is aligned, that byte is the third A2.
- R6: `sync_out` is high for exactly one cycle per match, and only together with `byte_stb`.
- R7: While `framer_en` is low, no sync pulse is produced, the byte boundary is not moved, and bytes keep flowing.
- R8: While `loss_n` is low, the incoming bits are taken as zero. A byte whose bits all arrive during loss reads 8'h00, and no match occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ser_in | input | 1 | Serial line data, one bit per clock |
| loss_n | input | 1 | Signal present when high; low forces data to zero |
| oof | input | 1 | Out-of-frame level; high permits re-alignment |
| framer_en | input | 1 | Frame detector enable; low suppresses sync pulses |
| rate_sts3 | input | 1 | 1 = STS-3 pattern length, 0 = STS-12 |
| byte_out | output | 8 | Assembled byte, MSB first-received |
| byte_stb | output | 1 | One-cycle strobe per completed byte |
| sync_out | output | 1 | Frame sync pulse, coincident with a strobe |

## Verification
The hardest situation to reach is a pattern that ends in the middle of a byte. The test has to show both outcomes of that case. With `oof` low, the boundary must stay put and the sync must come on a later, mixed byte. With `oof` high, the boundary must jump and emit an A2 byte early. The stimulus gets there by sending a few odd bits after reset, which shifts the pattern off the byte grid by a known offset. The pattern is then sent once under each `oof` level, and a bench model that tracks the bit phase predicts the exact strobe cycle and contents. The same offset trick, combined with the short pattern in STS-12 mode and with `framer_en` low, shows that neither case matches or moves the boundary.

// File: rtl/sbf_pkg.sv
package sbf_pkg;

    localparam int BYTE_W    = 8;
    localparam int A1_LONG   = 12;
    localparam int A1_SHORT  = 3;
    localparam int A2_CNT    = 3;
    localparam int WIN_BYTES = A1_LONG + A2_CNT;
    localparam int WIN_W     = BYTE_W * WIN_BYTES;

    localparam logic [BYTE_W-1:0] A1_CODE = 8'hF6;
    localparam logic [BYTE_W-1:0] A2_CODE = 8'h28;

    typedef enum logic {
        RATE_STS12 = 1'b0,
        RATE_STS3  = 1'b1
    } rate_e;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              stb;
        logic              sync;
    } byte_port_t;

    // Pattern as seen in a shift window whose newest bit sits at index 0.
    function automatic logic [WIN_W-1:0] frame_pattern(input int n_a1);
        logic [WIN_W-1:0] p;
        p = '0;
        for (int b = 0; b < WIN_BYTES; b++) begin
            if (b < A2_CNT)
                p[b*BYTE_W +: BYTE_W] = A2_CODE;
            else if (b < A2_CNT + n_a1)
                p[b*BYTE_W +: BYTE_W] = A1_CODE;
        end
        return p;
    endfunction

    function automatic logic [WIN_W-1:0] frame_mask(input int n_a1);
        logic [WIN_W-1:0] m;
        m = '0;
        for (int b = 0; b < WIN_BYTES; b++) begin
            if (b < A2_CNT + n_a1)
                m[b*BYTE_W +: BYTE_W] = '1;
        end
        return m;
    endfunction

endpackage

// File: rtl/sbf_shifter.sv
module sbf_shifter
    import sbf_pkg::*;
#(
    parameter int WIN_W_P = WIN_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ser_i,
    input  logic               loss_n_i,
    output logic [WIN_W_P-1:0] win_next_o
);

    logic [WIN_W_P-1:0] sh_q;
    logic               bit_in;

    // Loss of signal quiets the stream at its entry point.
    assign bit_in     = ser_i & loss_n_i;
    assign win_next_o = {sh_q[WIN_W_P-2:0], bit_in};

    always_ff @(posedge clk) begin
        if (!rst_n)
            sh_q <= '0;
        else
            sh_q <= win_next_o;
    end

endmodule

// File: rtl/sbf_matcher.sv
module sbf_matcher
    import sbf_pkg::*;
#(
    parameter int WIN_W_P = WIN_W
) (
    input  logic [WIN_W_P-1:0] win_i,
    input  rate_e              rate_i,
    output logic               match_o
);

    logic [1:0] rate_hit;

    for (genvar r = 0; r < 2; r++) begin : g_rate
        localparam int               NA1  = (r == int'(RATE_STS3)) ? A1_SHORT : A1_LONG;
        localparam logic [WIN_W-1:0] PAT  = frame_pattern(NA1);
        localparam logic [WIN_W-1:0] MASK = frame_mask(NA1);
        assign rate_hit[r] = ((win_i & MASK[WIN_W_P-1:0]) == PAT[WIN_W_P-1:0]);
    end

    assign match_o = rate_hit[rate_i];

endmodule

// File: rtl/sbf_aligner.sv
module sbf_aligner
    import sbf_pkg::*;
#(
    parameter int BYTE_W_P = BYTE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [BYTE_W_P-1:0] win_byte_i,
    input  logic                match_i,
    input  logic                oof_i,
    input  logic                fen_i,
    output byte_port_t          out_o
);

    localparam int                PH_W    = $clog2(BYTE_W_P);
    localparam logic [PH_W-1:0]   PH_LAST = PH_W'(BYTE_W_P - 1);

    logic [PH_W-1:0] ph_q;
    logic            pend_q;
    byte_port_t      out_q;
    logic            hit;
    logic            close_byte;

    assign hit        = match_i & fen_i;
    // A byte closes at the end of its 8 bits or when a search re-aligns.
    assign close_byte = (ph_q == PH_LAST) | (hit & oof_i);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q   <= '0;
            pend_q <= 1'b0;
            out_q  <= '0;
        end else begin
            out_q.stb <= close_byte;
            if (close_byte) begin
                out_q.data <= win_byte_i;
                out_q.sync <= fen_i & (hit | pend_q);
                ph_q       <= '0;
                pend_q     <= 1'b0;
            end else begin
                out_q.sync <= 1'b0;
                ph_q       <= ph_q + 1'b1;
                pend_q     <= fen_i & (pend_q | hit);
            end
        end
    end

    assign out_o = out_q;

    AST_REALIGN_A2: assert property (@(posedge clk) disable iff (!rst_n)
        match_i && fen_i && oof_i |=> out_q.sync && out_q.stb && out_q.data == A2_CODE); // R4
    AST_FEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !fen_i |=> !out_q.sync); // R7
    AST_SYNC_WITH_STB: assert property (@(posedge clk) disable iff (!rst_n)
        out_q.sync |-> out_q.stb); // R6
    AST_SYNC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        out_q.sync |=> !out_q.sync); // R6

endmodule

// File: rtl/sonet_byte_framer.sv
module sonet_byte_framer
    import sbf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_in,
    input  logic              loss_n,
    input  logic              oof,
    input  logic              framer_en,
    input  logic              rate_sts3,
    output logic [BYTE_W-1:0] byte_out,
    output logic              byte_stb,
    output logic              sync_out
);

    logic [WIN_W-1:0] win_next;
    logic             match;
    rate_e            rate;
    byte_port_t       port;

    assign rate = rate_e'(rate_sts3);

    sbf_shifter #(.WIN_W_P(WIN_W)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .ser_i      (ser_in),
        .loss_n_i   (loss_n),
        .win_next_o (win_next)
    );

    sbf_matcher #(.WIN_W_P(WIN_W)) u_match (
        .win_i   (win_next),
        .rate_i  (rate),
        .match_o (match)
    );

    sbf_aligner #(.BYTE_W_P(BYTE_W)) u_align (
        .clk        (clk),
        .rst_n      (rst_n),
        .win_byte_i (win_next[BYTE_W-1:0]),
        .match_i    (match),
        .oof_i      (oof),
        .fen_i      (framer_en),
        .out_o      (port)
    );

    assign byte_out = port.data;
    assign byte_stb = port.stb;
    assign sync_out = port.sync;

endmodule

// File: tb/sonet_byte_framer_tb.sv
module sonet_byte_framer_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int LWIN       = 120;
    localparam int SWIN       = 48;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_in = 1'b0;
    logic       loss_n = 1'b1;
    logic       oof = 1'b0;
    logic       framer_en = 1'b1;
    logic       rate_sts3 = 1'b0;
    logic [7:0] byte_out;
    logic       byte_stb;
    logic       sync_out;

    always #(CLK_PERIOD/2) clk = ~clk;

    sonet_byte_framer dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ser_in    (ser_in),
        .loss_n    (loss_n),
        .oof       (oof),
        .framer_en (framer_en),
        .rate_sts3 (rate_sts3),
        .byte_out  (byte_out),
        .byte_stb  (byte_stb),
        .sync_out  (sync_out)
    );

    typedef struct {
        int         edge_n;
        logic [7:0] data;
        logic       sync;
    } exp_t;

    exp_t            expq[$];
    int              checks = 0;
    int              fails = 0;
    int              edge_cnt = 0;
    int              sync_seen = 0;
    string           cur_tag = "R2";
    logic [LWIN-1:0] hist;
    logic [LWIN-1:0] pat_l;
    logic [SWIN-1:0] pat_s;
    int              ph_m = 0;
    bit              pend_m = 1'b0;

    always @(posedge clk) edge_cnt <= edge_cnt + 1;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard as strobes appear.
    always @(negedge clk) begin
        if (sync_out && !byte_stb)
            chk(1'b0, "R6 sync without strobe", 1, 0);
        if (byte_stb) begin
            if (sync_out) sync_seen++;
            if (expq.size() == 0) begin
                chk(1'b0, {cur_tag, " unexpected strobe"}, edge_cnt, 0);
            end else begin
                exp_t e;
                e = expq.pop_front();
                chk(e.edge_n == edge_cnt, {cur_tag, " R1 strobe cycle"}, edge_cnt, e.edge_n);
                chk(e.data == byte_out, {cur_tag, " byte"}, byte_out, e.data);
                chk(e.sync == sync_out, {cur_tag, " R6 sync"}, sync_out, e.sync);
            end
        end else if (expq.size() > 0 && expq[0].edge_n <= edge_cnt) begin
            exp_t e;
            e = expq.pop_front();
            chk(1'b0, {cur_tag, " missing strobe"}, 0, e.edge_n);
        end
    end

    // Driver with a behavioural model of the requirements.
    task automatic send_bit(input logic b);
        logic eb;
        bit   full, hit, closes;
        @(negedge clk);
        rst_n  = 1'b1;
        ser_in = b;
        eb     = b & loss_n;                          // R8: loss forces zero
        hist   = {hist[LWIN-2:0], eb};
        full   = rate_sts3 ? (hist[SWIN-1:0] == pat_s) : (hist == pat_l); // R3
        hit    = full && framer_en;
        closes = (ph_m == 7) || (hit && oof);         // R4 re-alignment
        if (closes) begin
            expq.push_back('{edge_cnt + 1, hist[7:0], framer_en && (hit || pend_m)});
            ph_m   = 0;
            pend_m = 1'b0;
        end else begin
            ph_m++;
            pend_m = framer_en && (pend_m || hit);    // R5 report later
        end
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
    endtask

    task automatic send_frame(input int n_a1);
        for (int i = 0; i < n_a1; i++) send_byte(8'hF6);
        for (int i = 0; i < 3; i++) send_byte(8'h28);
    endtask

    task automatic flush_and_count(input int exp_syncs, input string tag);
        for (int i = 0; i < 10; i++) send_bit(1'b0);
        chk(sync_seen == exp_syncs, tag, sync_seen, exp_syncs);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n  = 1'b0;
        ser_in = 1'b0;
        hist   = '0;
        ph_m   = 0;
        pend_m = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(byte_out == 8'h00, "R2 reset byte_out", byte_out, 0);
        chk(byte_stb == 1'b0, "R2 reset byte_stb", byte_stb, 0);
        chk(sync_out == 1'b0, "R2 reset sync_out", sync_out, 0);
        sync_seen = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        pat_l = '0;
        for (int i = 0; i < 12; i++) pat_l = {pat_l[LWIN-9:0], 8'hF6};
        for (int i = 0; i < 3; i++)  pat_l = {pat_l[LWIN-9:0], 8'h28};
        pat_s = '0;
        for (int i = 0; i < 3; i++) pat_s = {pat_s[SWIN-9:0], 8'hF6};
        for (int i = 0; i < 3; i++) pat_s = {pat_s[SWIN-9:0], 8'h28};

        // R2 then R1: offset-0 boundary and MSB-first bytes
        do_reset();
        cur_tag = "R2";
        send_byte(8'hA5);
        cur_tag = "R1";
        for (int i = 0; i < 12; i++) send_byte(8'(8'h3C + i * 37));
        flush_and_count(0, "R1 no sync on plain data");

        // R5: aligned pattern with oof low, sync on third A2
        do_reset();
        cur_tag = "R5";
        send_byte(8'h11);
        send_frame(12);
        send_byte(8'h77);
        flush_and_count(1, "R5 aligned sync count");

        // R5: pattern off the byte grid, boundary kept
        do_reset();
        cur_tag = "R5";
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        send_frame(12);
        for (int i = 0; i < 3; i++) send_byte(8'h5A);
        flush_and_count(1, "R5 unaligned sync count");

        // R4: search with oof high re-aligns
        do_reset();
        cur_tag = "R4";
        oof = 1'b1;
        for (int i = 0; i < 5; i++) send_bit(1'(i));
        send_frame(12);
        for (int i = 0; i < 4; i++) send_byte(8'(8'hC3 + i));
        flush_and_count(1, "R4 realign sync count");

        // R3: short pattern in STS-3 mode
        do_reset();
        cur_tag = "R3";
        rate_sts3 = 1'b1;
        send_bit(1'b1); send_bit(1'b1);
        send_frame(3);
        send_byte(8'h0F); send_byte(8'hE1);
        flush_and_count(1, "R3 short pattern matches in STS-3");

        // R3: short pattern ignored in STS-12 mode
        do_reset();
        cur_tag = "R3";
        rate_sts3 = 1'b0;
        send_bit(1'b0);
        send_frame(3);
        send_byte(8'h99);
        flush_and_count(0, "R3 short pattern ignored in STS-12");

        // R7: framer disabled, no sync and no realign
        do_reset();
        cur_tag = "R7";
        framer_en = 1'b0;
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        send_frame(12);
        for (int i = 0; i < 3; i++) send_byte(8'h6B);
        flush_and_count(0, "R7 disabled sync count");
        framer_en = 1'b1;

        // R8: loss of signal zeroes data and blocks matches
        do_reset();
        cur_tag = "R8";
        loss_n = 1'b0;
        send_byte(8'hFF);
        send_frame(12);
        send_byte(8'hA5);
        flush_and_count(0, "R8 no sync during loss");
        loss_n = 1'b1;
        send_byte(8'hB4);
        send_byte(8'h4B);
        flush_and_count(0, "R8 data resumes");
        oof = 1'b0;

        @(negedge clk);
        chk(expq.size() == 0, "R1 scoreboard drained", expq.size(), 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule